// File: doc/BRIEF.md
# Spike Fan-out Encoder with Shared Connection Store

This block sits between a cluster of 16 spiking neuron outputs and a mesh router. Whenever a cluster output fires, the block turns that single event into a train of packets, one for each synaptic connection programmed for that output. Every packet names a destination tile (X and Y), a neuron inside that tile and a synapse on that neuron.

Connection entries live in a store of 64 blocks, each holding 16 entries. An ownership table holds one 64-bit bitmap per output. A set bit hands the matching block to that output, so the fan-out of an output grows by 16 entries for each block it is given. A fixed mode can be selected instead. In that mode the table is not used and every output owns four consecutive blocks. Spikes are queued in a pending vector and served one output at a time. Packets leave over a valid/ready handshake.

Top module: `spike_fanout_encoder`

## Requirements
- R1: After reset no packet is offered, `busy_o` and `overflow_o` are 0, every store entry is invalid and every ownership row is all zeros.
- R2: A write to the store puts bit 18 as the valid flag, bits 17:14 as X, bits 13:10 as Y, bits 9:6 as neuron and bits 5:0 as synapse at address block*16+entry. When an output fires, one packet carrying bits 17:0 of the entry is emitted for each valid entry in each block that the output owns. Invalid entries emit nothing.
- R3: Writing a row to the ownership table sets which blocks belong to that output: bit b gives block b. Clearing a bit removes that block from the output's next fan-out.
- R4: An output whose ownership row is all zeros emits no packets when it fires.
- R5: While `fixed_mode_i` is 1, output k owns exactly blocks 4k, 4k+1, 4k+2 and 4k+3, and its table row has no effect.
- R6: Pending outputs are served in ascending index order. Within an output, blocks are walked in ascending order, and entries 0 to 15 are walked in order inside each block.
- R7: At most one packet is transferred per clock. While `pkt_valid_o` is 1 and `pkt_ready_i` is 0, the packet stays offered with unchanged contents.
- R8: A spike for an output that is already pending is merged into the pending bit, so that output is served once. The merge sets `overflow_o`, which then stays 1 until reset.
- R9: When the block is idle, a spike sampled at one clock edge raises `busy_o` at that edge, and the first packet is offered after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spike_i | input | 16 | One bit per cluster output, sampled each clock |
| fixed_mode_i | input | 1 | 1 selects four fixed blocks per output |
| tbl_we_i | input | 1 | Ownership table write strobe |
| tbl_row_i | input | 4 | Output whose row is written |
| tbl_mask_i | input | 64 | Block ownership bitmap for that row |
| mem_we_i | input | 1 | Store write strobe |
| mem_addr_i | input | 10 | Store address, block*16+entry |
| mem_wdata_i | input | 19 | Entry {valid, X, Y, neuron, synapse} |
| pkt_valid_o | output | 1 | A packet is offered |
| pkt_ready_i | input | 1 | Router accepts the offered packet |
| pkt_dest_o | output | 18 | Packet {X, Y, neuron, synapse} |
| busy_o | output | 1 | Spikes pending or a fan-out in progress |
| overflow_o | output | 1 | Sticky flag: a spike was merged into a pending one |

## Verification
A spike sampled at an edge is seen as `busy_o` after that edge, and its first packet is seen after the next edge. The bench drives inputs and samples outputs on the falling edge, and it checks that two-edge spacing directly. Each packet is counted as transferred in the cycle where valid and ready are both seen at the sample point, and is compared in order against a list built from the bench's own copy of the table and the store. A stalled packet is checked again on the next falling edge for unchanged contents. The overflow flag is checked at the sample that follows the edge where the second, merged spike is taken.

// File: rtl/spkenc_pkg.sv
package spkenc_pkg;
    localparam int COORD_W = 4;
    localparam int NRN_W   = 4;
    localparam int SYN_W   = 6;

    typedef struct packed {
        logic [COORD_W-1:0] dx;
        logic [COORD_W-1:0] dy;
        logic [NRN_W-1:0]   nrn;
        logic [SYN_W-1:0]   syn;
    } dest_t;

    typedef struct packed {
        logic  vld;
        dest_t dst;
    } conn_t;

    localparam int DEST_W = $bits(dest_t);
    localparam int CONN_W = $bits(conn_t);
endpackage

// File: rtl/alloc_table.sv
module alloc_table #(
    parameter int NUM_OUT = 16,
    parameter int NUM_BLK = 64,
    localparam int OUT_W = $clog2(NUM_OUT)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [OUT_W-1:0]   wrow_i,
    input  logic [NUM_BLK-1:0] wmask_i,
    input  logic [OUT_W-1:0]   rrow_i,
    output logic [NUM_BLK-1:0] rmask_o
);
    logic [NUM_BLK-1:0] rows_d [NUM_OUT];
    logic [NUM_BLK-1:0] rows_q [NUM_OUT];

    always_comb begin
        for (int r = 0; r < NUM_OUT; r++) rows_d[r] = rows_q[r];
        if (we_i) rows_d[wrow_i] = wmask_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int r = 0; r < NUM_OUT; r++) rows_q[r] <= '0;
        end else begin
            for (int r = 0; r < NUM_OUT; r++) rows_q[r] <= rows_d[r];
        end
    end

    assign rmask_o = rows_q[rrow_i];
endmodule

// File: rtl/topo_store.sv
module topo_store
    import spkenc_pkg::*;
#(
    parameter int NUM_BLK = 64,
    parameter int BLK_ENT = 16,
    localparam int DEPTH  = NUM_BLK * BLK_ENT,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  conn_t             wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output conn_t             rdata_o
);
    logic [DEPTH-1:0] vld_d, vld_q;
    dest_t            pay_q [DEPTH];

    always_comb begin
        vld_d = vld_q;
        if (we_i) vld_d[waddr_i] = wdata_i.vld;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vld_q <= '0;
        else         vld_q <= vld_d;
    end

    always_ff @(posedge clk_i) begin
        if (we_i) pay_q[waddr_i] <= wdata_i.dst;
    end

    assign rdata_o = '{vld: vld_q[raddr_i], dst: pay_q[raddr_i]};
endmodule

// File: rtl/pend_arb.sv
module pend_arb #(
    parameter int NUM_OUT = 16,
    localparam int OUT_W = $clog2(NUM_OUT)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_OUT-1:0] spike_i,
    input  logic               take_i,
    output logic               any_o,
    output logic [OUT_W-1:0]   pick_o,
    output logic               ovf_o
);
    typedef struct packed {
        logic [NUM_OUT-1:0] pend;
        logic               ovf;
    } arb_t;

    arb_t               s_d, s_q;
    logic [NUM_OUT-1:0] clr;

    always_comb begin
        pick_o = '0;
        for (int i = NUM_OUT - 1; i >= 0; i--) begin
            if (s_q.pend[i]) pick_o = OUT_W'(i);
        end
        clr = '0;
        if (take_i) clr[pick_o] = 1'b1;
        s_d      = s_q;
        s_d.pend = (s_q.pend & ~clr) | spike_i;
        if ((spike_i & s_q.pend & ~clr) != '0) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign any_o = |s_q.pend;
    assign ovf_o = s_q.ovf;
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
    parameter int NUM_OUT  = 16,
    parameter int NUM_BLK  = 64,
    parameter int BLK_ENT  = 16,
    parameter int FIX_BLKS = 4,
    localparam int OUT_W  = $clog2(NUM_OUT),
    localparam int BLK_W  = $clog2(NUM_BLK),
    localparam int ENT_W  = $clog2(BLK_ENT),
    localparam int ADDR_W = BLK_W + ENT_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pend_any_i,
    input  logic [OUT_W-1:0]   pick_i,
    output logic               take_o,
    output logic [OUT_W-1:0]   row_sel_o,
    input  logic [NUM_BLK-1:0] tbl_mask_i,
    input  logic               fixed_mode_i,
    input  logic               ent_vld_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic [ADDR_W-1:0]  raddr_o,
    output logic               busy_o,
    output logic [OUT_W-1:0]   cur_out_o,
    output logic [BLK_W-1:0]   cur_blk_o
);
    localparam logic [ENT_W-1:0] ENT_LAST = ENT_W'(BLK_ENT - 1);

    typedef struct packed {
        logic             busy;
        logic [OUT_W-1:0] out;
        logic [BLK_W-1:0] blk;
        logic [ENT_W-1:0] ent;
    } scan_t;

    scan_t              s_d, s_q;
    logic [NUM_BLK-1:0] fix_mask, eff_mask;
    logic [BLK_W:0]     nxt;

    function automatic logic [BLK_W:0] next_set(input logic [NUM_BLK-1:0] m, input int from);
        logic [BLK_W:0] r;
        r = '0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (m[i] && i >= from) r = {1'b1, BLK_W'(i)};
        end
        return r;
    endfunction

    assign row_sel_o = s_q.busy ? s_q.out : pick_i;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_fix
        assign fix_mask[b] = ((b / FIX_BLKS) == int'(row_sel_o));
    end

    assign eff_mask = fixed_mode_i ? fix_mask : tbl_mask_i;

    always_comb begin
        s_d    = s_q;
        take_o = 1'b0;
        nxt    = '0;
        if (!s_q.busy) begin
            if (pend_any_i) begin
                take_o = 1'b1;
                nxt    = next_set(eff_mask, 0);
                if (nxt[BLK_W]) begin
                    s_d.busy = 1'b1;
                    s_d.out  = pick_i;
                    s_d.blk  = nxt[BLK_W-1:0];
                    s_d.ent  = '0;
                end
            end
        end else if (!(ent_vld_i && !ready_i)) begin
            if (s_q.ent != ENT_LAST) begin
                s_d.ent = s_q.ent + 1'b1;
            end else begin
                nxt = next_set(eff_mask, int'(s_q.blk) + 1);
                if (nxt[BLK_W]) begin
                    s_d.blk = nxt[BLK_W-1:0];
                    s_d.ent = '0;
                end else begin
                    s_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign valid_o   = s_q.busy && ent_vld_i;
    assign raddr_o   = {s_q.blk, s_q.ent};
    assign busy_o    = s_q.busy;
    assign cur_out_o = s_q.out;
    assign cur_blk_o = s_q.blk;
endmodule

// File: rtl/spike_fanout_encoder.sv
module spike_fanout_encoder
    import spkenc_pkg::*;
#(
    parameter int NUM_OUT  = 16,
    parameter int NUM_BLK  = 64,
    parameter int BLK_ENT  = 16,
    parameter int FIX_BLKS = 4,
    localparam int OUT_W  = $clog2(NUM_OUT),
    localparam int BLK_W  = $clog2(NUM_BLK),
    localparam int ADDR_W = BLK_W + $clog2(BLK_ENT)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_OUT-1:0] spike_i,
    input  logic               fixed_mode_i,
    input  logic               tbl_we_i,
    input  logic [OUT_W-1:0]   tbl_row_i,
    input  logic [NUM_BLK-1:0] tbl_mask_i,
    input  logic               mem_we_i,
    input  logic [ADDR_W-1:0]  mem_addr_i,
    input  logic [CONN_W-1:0]  mem_wdata_i,
    output logic               pkt_valid_o,
    input  logic               pkt_ready_i,
    output logic [DEST_W-1:0]  pkt_dest_o,
    output logic               busy_o,
    output logic               overflow_o
);
    logic               pend_any, take, scan_busy;
    logic [OUT_W-1:0]   pick, row_sel, cur_out;
    logic [BLK_W-1:0]   cur_blk;
    logic [NUM_BLK-1:0] row_mask;
    logic [ADDR_W-1:0]  raddr;
    conn_t              rd_conn;

    alloc_table #(.NUM_OUT(NUM_OUT), .NUM_BLK(NUM_BLK)) u_table (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (tbl_we_i),
        .wrow_i  (tbl_row_i),
        .wmask_i (tbl_mask_i),
        .rrow_i  (row_sel),
        .rmask_o (row_mask)
    );

    topo_store #(.NUM_BLK(NUM_BLK), .BLK_ENT(BLK_ENT)) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (mem_we_i),
        .waddr_i (mem_addr_i),
        .wdata_i (conn_t'(mem_wdata_i)),
        .raddr_i (raddr),
        .rdata_o (rd_conn)
    );

    pend_arb #(.NUM_OUT(NUM_OUT)) u_pend (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .spike_i (spike_i),
        .take_i  (take),
        .any_o   (pend_any),
        .pick_o  (pick),
        .ovf_o   (overflow_o)
    );

    scan_ctrl #(
        .NUM_OUT(NUM_OUT), .NUM_BLK(NUM_BLK),
        .BLK_ENT(BLK_ENT), .FIX_BLKS(FIX_BLKS)
    ) u_scan (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pend_any_i   (pend_any),
        .pick_i       (pick),
        .take_o       (take),
        .row_sel_o    (row_sel),
        .tbl_mask_i   (row_mask),
        .fixed_mode_i (fixed_mode_i),
        .ent_vld_i    (rd_conn.vld),
        .ready_i      (pkt_ready_i),
        .valid_o      (pkt_valid_o),
        .raddr_o      (raddr),
        .busy_o       (scan_busy),
        .cur_out_o    (cur_out),
        .cur_blk_o    (cur_blk)
    );

    assign pkt_dest_o = rd_conn.dst;
    assign busy_o     = scan_busy | pend_any;
endmodule

// File: rtl/spkenc_chk.sv
module spkenc_chk #(
    parameter int NUM_OUT  = 16,
    parameter int NUM_BLK  = 64,
    parameter int FIX_BLKS = 4,
    parameter int DEST_W   = 18,
    localparam int OUT_W = $clog2(NUM_OUT),
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_OUT-1:0] spike_i,
    input logic               fixed_mode_i,
    input logic               pkt_valid_o,
    input logic               pkt_ready_i,
    input logic [DEST_W-1:0]  pkt_dest_o,
    input logic               busy_o,
    input logic               overflow_o,
    input logic [OUT_W-1:0]   cur_out,
    input logic [BLK_W-1:0]   cur_blk
);
    // R7
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_dest_o));

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !pkt_valid_o);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |=> overflow_o);

    // R8
    ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(overflow_o) |-> $past(spike_i != '0));

    // R5
    fixed_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_valid_o && fixed_mode_i |-> (int'(cur_blk) / FIX_BLKS) == int'(cur_out));
endmodule

bind spike_fanout_encoder spkenc_chk #(
    .NUM_OUT(NUM_OUT), .NUM_BLK(NUM_BLK), .FIX_BLKS(FIX_BLKS), .DEST_W(spkenc_pkg::DEST_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .spike_i      (spike_i),
    .fixed_mode_i (fixed_mode_i),
    .pkt_valid_o  (pkt_valid_o),
    .pkt_ready_i  (pkt_ready_i),
    .pkt_dest_o   (pkt_dest_o),
    .busy_o       (busy_o),
    .overflow_o   (overflow_o),
    .cur_out      (cur_out),
    .cur_blk      (cur_blk)
);

// File: tb/spike_fanout_encoder_tb.sv
module spike_fanout_encoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [15:0] spike = '0;
    logic        fixed_mode = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_row = '0;
    logic [63:0] tbl_mask = '0;
    logic        mem_we = 1'b0;
    logic [9:0]  mem_addr = '0;
    logic [18:0] mem_wdata = '0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b0;
    logic [17:0] pkt_dest;
    logic        busy, overflow;

    always #5 clk = ~clk;

    spike_fanout_encoder dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .spike_i(spike), .fixed_mode_i(fixed_mode),
        .tbl_we_i(tbl_we), .tbl_row_i(tbl_row), .tbl_mask_i(tbl_mask),
        .mem_we_i(mem_we), .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata),
        .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready), .pkt_dest_o(pkt_dest),
        .busy_o(busy), .overflow_o(overflow)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic        sh_vld [1024];
    logic [17:0] sh_pay [1024];
    logic [63:0] sh_tbl [16];
    logic [17:0] exp_q [$];

    // fields: {fixed, ready mode[1:0], spikes[15:0]}
    localparam logic [18:0] VEC [7] = '{
        {1'b0, 2'd0, 16'h0001},
        {1'b0, 2'd1, 16'h0004},
        {1'b0, 2'd0, 16'h0008},
        {1'b0, 2'd2, 16'h8005},
        {1'b1, 2'd1, 16'h0003},
        {1'b1, 2'd0, 16'h8000},
        {1'b0, 2'd2, 16'hC000}
    };
    localparam int USED_BLK [12] = '{0, 1, 2, 3, 4, 5, 7, 10, 60, 61, 62, 63};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] pay_of(input int a);
        logic [9:0] x;
        x = a[9:0];
        return {x[3:0] ^ x[9:6], x[9:6], x[3:0] + 4'd3, x[5:0] ^ 6'h2A};
    endfunction

    task automatic wr_mem(input int a, input logic v, input logic [17:0] p);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = a[9:0]; mem_wdata = {v, p};
        sh_vld[a] = v; sh_pay[a] = p;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic wr_tbl(input int r, input logic [63:0] m);
        @(negedge clk);
        tbl_we = 1'b1; tbl_row = r[3:0]; tbl_mask = m;
        sh_tbl[r] = m;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic build(input logic [15:0] sp, input logic fx);
        for (int k = 0; k < 16; k++) begin
            if (sp[k]) begin
                logic [63:0] m;
                m = fx ? (64'hF << (4 * k)) : sh_tbl[k];
                for (int b = 0; b < 64; b++)
                    if (m[b])
                        for (int e = 0; e < 16; e++)
                            if (sh_vld[b*16+e]) exp_q.push_back(sh_pay[b*16+e]);
            end
        end
    endtask

    task automatic fire(input logic [15:0] sp);
        @(negedge clk);
        pkt_ready = 1'b0;
        spike = sp;
        @(negedge clk);
        spike = '0;
    endtask

    task automatic collect(input int rmode, input string req);
        int got = 0;
        int cyc = 0;
        bit stall = 0;
        logic [17:0] sd = '0;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            #1;
            if (stall) chk(pkt_valid && pkt_dest == sd, "R7 stalled packet held", {13'd0, pkt_valid, pkt_dest}, {13'd0, 1'b1, sd});
            pkt_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : ((cyc % 3) != 0);
            #1;
            stall = pkt_valid && !pkt_ready;
            sd = pkt_dest;
            if (pkt_valid && pkt_ready) begin
                if (got < exp_q.size()) chk(pkt_dest == exp_q[got], req, {14'd0, pkt_dest}, {14'd0, exp_q[got]});
                got++;
            end
            if (!busy && !pkt_valid) break;
        end
        chk(got == exp_q.size(), {req, " packet count"}, got, exp_q.size());
        pkt_ready = 1'b0;
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin sh_vld[i] = 1'b0; sh_pay[i] = '0; end
        for (int i = 0; i < 16; i++) sh_tbl[i] = '0;
        repeat (5) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(!pkt_valid, "R1 valid after reset", pkt_valid, 0);
        chk(!busy, "R1 busy after reset", busy, 0);
        chk(!overflow, "R1 overflow after reset", overflow, 0);

        // R1 store empty after reset: full row yields nothing
        wr_tbl(0, '1);
        fire(16'h0001);
        collect(0, "R1 empty store");

        // store contents: selected blocks, valid on entries 0,3,6,9,12,15
        foreach (USED_BLK[j]) begin
            for (int e = 0; e < 16; e++) begin
                int a;
                a = USED_BLK[j] * 16 + e;
                wr_mem(a, (e % 3 == 0), pay_of(a));
            end
        end
        wr_tbl(0, 64'h21);                 // blocks 0,5
        wr_tbl(2, (64'h1 << 63) | (64'h1 << 10));
        wr_tbl(3, 64'h0);
        wr_tbl(14, (64'h1 << 61) | (64'h1 << 62));
        wr_tbl(15, 64'h80);                // block 7

        // R2 R3 R4 R5 R6 vector walk
        foreach (VEC[v]) begin
            fixed_mode = VEC[v][18];
            build(VEC[v][15:0], VEC[v][18]);
            fire(VEC[v][15:0]);
            collect(int'(VEC[v][17:16]), $sformatf("R2 R6 vector %0d", v));
        end
        fixed_mode = 1'b0;

        // R9 latency from idle
        build(16'h0001, 1'b0);
        @(negedge clk);
        pkt_ready = 1'b0;
        spike = 16'h0001;
        @(negedge clk);
        #1;
        chk(busy, "R9 busy one edge after spike", busy, 1);
        chk(!pkt_valid, "R9 no packet one edge after spike", pkt_valid, 0);
        spike = '0;
        @(negedge clk);
        #1;
        chk(pkt_valid && pkt_dest == exp_q[0], "R9 first packet two edges after spike", {13'd0, pkt_valid, pkt_dest}, {13'd0, 1'b1, exp_q[0]});
        collect(0, "R9 rest of fan-out");

        // R3 release of block 5 from output 0
        wr_tbl(0, 64'h1);
        build(16'h0001, 1'b0);
        fire(16'h0001);
        collect(1, "R3 released block");

        // R8 merge into pending and sticky overflow
        build(16'h0004, 1'b0);
        build(16'h0001, 1'b0);
        fire(16'h0004);
        spike = 16'h0001;
        @(negedge clk);
        #1;
        chk(!overflow, "R8 overflow clear before merge", overflow, 0);
        spike = 16'h0001;
        @(negedge clk);
        #1;
        chk(overflow, "R8 overflow after merge", overflow, 1);
        spike = '0;
        collect(0, "R8 merged spike served once");
        chk(overflow, "R8 overflow sticky", overflow, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule